// File: doc/BRIEF.md
# Blinking Six-Digit Field Display

This block turns three two-digit BCD fields into the segment patterns for six seven-segment digits. The fields are an alarm slot number, an hour and a minute. Each digit has its own set of segment lines, and the outputs are static: there is no scanning. An editing controller elsewhere supplies the field values and a small mode code. The mode code picks which field, if any, flashes so that the user can see what is being changed.

A free-running timer in the block inverts a blink phase flag once every `BLINK_PERIOD` clock cycles. While the phase is off, the selected digits go dark. While it is on, every digit shows its value. When the mode code changes, the phase returns to on and the timer restarts. This makes a newly selected field visible at once.

Top module: `sixdigit_blink_disp`

## Requirements
- R1: Digits are ordered left to right as slot tens, slot units, hour tens, hour units, minute tens, minute units. Each digit takes its value from the upper or lower nibble of its field byte (upper nibble for tens). Segment bit 0 is segment a and bit 6 is segment g, active high. BCD 0..9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R2: A nibble above 9 drives all seven segment lines of its digit low, whatever the blink state.
- R3: Mode value 0 keeps every digit lit through complete on and off phases of the timer.
- R4: Mode value 1 darkens only the two minute digits during the off phase.
- R5: Mode value 2 darkens only the two hour digits during the off phase.
- R6: Mode value 3 darkens only the two slot-number digits during the off phase.
- R7: Mode value 4 darkens all six digits during the off phase.
- R8: With the mode held, the phase stays on for `BLINK_PERIOD` clock cycles, then off for `BLINK_PERIOD` cycles, and so on.
- R9: Any change of the mode value, seen at a clock edge, sets the phase to on at that edge and restarts the timer. A full on phase of `BLINK_PERIOD` cycles follows.
- R10: Mode values 5, 6 and 7 behave like mode 0.
- R11: After reset the phase is on, the stored mode is 0 and the timer is at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slotBcd | input | 8 | Alarm slot number, two BCD digits |
| hourBcd | input | 8 | Hour, two BCD digits |
| minuteBcd | input | 8 | Minute, two BCD digits |
| blinkMode | input | 3 | Blink field select (0 none, 1 minute, 2 hour, 3 slot, 4 all) |
| segSlotTens | output | 7 | Segments of the leftmost digit |
| segSlotUnits | output | 7 | Segments of digit 2 |
| segHourTens | output | 7 | Segments of digit 3 |
| segHourUnits | output | 7 | Segments of digit 4 |
| segMinTens | output | 7 | Segments of digit 5 |
| segMinUnits | output | 7 | Segments of the rightmost digit |

## Verification
Every mode is driven with distinct values in all six digits. The expected dark mask is checked on the last cycle of the on phase and on the first cycle of the off phase. This separates a wrong field choice from a wrong phase length by one cycle. A sweep of the same digit through 0..9 in every position checks the decode table, and a pattern of six different digits checks the digit order. Fields holding nibbles A and F show that non-BCD values blank. Changing the mode in the middle of an off phase separates a true phase restart from a timer that simply keeps running.

// File: rtl/blink_disp_pkg.sv
package blink_disp_pkg;

  typedef enum logic [2:0] {
    BLINK_NONE  = 3'd0,
    BLINK_MIN   = 3'd1,
    BLINK_HOUR  = 3'd2,
    BLINK_SLOT  = 3'd3,
    BLINK_ALL   = 3'd4
  } blinkSel_e;

  // Strobes from control to datapath: darken a field group this cycle
  typedef struct packed {
    logic darkSlot;
    logic darkHour;
    logic darkMin;
  } darkStrobes_t;

  localparam int NUM_DIGITS = 6;
  localparam int SEG_W      = 7;

  // Segment bit 0 = a ... bit 6 = g, active high
  function automatic logic [SEG_W-1:0] bcdToSeg(input logic [3:0] nib);
    logic [SEG_W-1:0] s;
    case (nib)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/blink_ctrl.sv
module blink_ctrl
  import blink_disp_pkg::*;
#(
  parameter int BLINK_PERIOD = 125_000_000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   blinkMode,
  output darkStrobes_t strobes,
  output logic         phaseOn,
  output logic         tickPulse
);

  localparam int CNT_W = (BLINK_PERIOD > 2) ? $clog2(BLINK_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLINK_PERIOD - 1);

  logic [CNT_W-1:0] tickCnt;
  logic [2:0]       modeQ;
  logic             modeChange;
  logic             cntWrap;
  logic             selSlot, selHour, selMin;

  assign modeChange = (blinkMode != modeQ);
  assign cntWrap    = (tickCnt == CNT_LAST);
  assign tickPulse  = cntWrap && !modeChange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      phaseOn <= 1'b1;
      modeQ   <= 3'd0;
    end else begin
      modeQ <= blinkMode;
      if (modeChange) begin
        tickCnt <= '0;
        phaseOn <= 1'b1;
      end else if (cntWrap) begin
        tickCnt <= '0;
        phaseOn <= ~phaseOn;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  always_comb begin
    selSlot = 1'b0;
    selHour = 1'b0;
    selMin  = 1'b0;
    case (blinkSel_e'(blinkMode))
      BLINK_MIN:  selMin  = 1'b1;
      BLINK_HOUR: selHour = 1'b1;
      BLINK_SLOT: selSlot = 1'b1;
      BLINK_ALL: begin
        selSlot = 1'b1;
        selHour = 1'b1;
        selMin  = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    strobes.darkSlot = !phaseOn && selSlot;
    strobes.darkHour = !phaseOn && selHour;
    strobes.darkMin  = !phaseOn && selMin;
  end

endmodule

// File: rtl/blink_datapath.sv
module blink_datapath
  import blink_disp_pkg::*;
(
  input  logic [7:0]                         slotBcd,
  input  logic [7:0]                         hourBcd,
  input  logic [7:0]                         minuteBcd,
  input  darkStrobes_t                       strobes,
  output logic [NUM_DIGITS-1:0][SEG_W-1:0]   segBus
);

  logic [NUM_DIGITS-1:0][3:0] digitNib;
  logic [NUM_DIGITS-1:0]      digitDark;

  // index 0 is the leftmost digit
  assign digitNib  = {minuteBcd[3:0], minuteBcd[7:4],
                      hourBcd[3:0],   hourBcd[7:4],
                      slotBcd[3:0],   slotBcd[7:4]};
  assign digitDark = {strobes.darkMin,  strobes.darkMin,
                      strobes.darkHour, strobes.darkHour,
                      strobes.darkSlot, strobes.darkSlot};

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    assign segBus[d] = digitDark[d] ? '0 : bcdToSeg(digitNib[d]);
  end

endmodule

// File: rtl/sixdigit_blink_disp.sv
module sixdigit_blink_disp
  import blink_disp_pkg::*;
#(
  parameter int BLINK_PERIOD = 125_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] slotBcd,
  input  logic [7:0] hourBcd,
  input  logic [7:0] minuteBcd,
  input  logic [2:0] blinkMode,
  output logic [6:0] segSlotTens,
  output logic [6:0] segSlotUnits,
  output logic [6:0] segHourTens,
  output logic [6:0] segHourUnits,
  output logic [6:0] segMinTens,
  output logic [6:0] segMinUnits
);

  darkStrobes_t                      strobes;
  logic                              phaseOn;
  logic                              tickPulse;
  logic [NUM_DIGITS-1:0][SEG_W-1:0]  segBus;

  blink_ctrl #(.BLINK_PERIOD(BLINK_PERIOD)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .blinkMode (blinkMode),
    .strobes   (strobes),
    .phaseOn   (phaseOn),
    .tickPulse (tickPulse)
  );

  blink_datapath u_dp (
    .slotBcd   (slotBcd),
    .hourBcd   (hourBcd),
    .minuteBcd (minuteBcd),
    .strobes   (strobes),
    .segBus    (segBus)
  );

  assign segSlotTens  = segBus[0];
  assign segSlotUnits = segBus[1];
  assign segHourTens  = segBus[2];
  assign segHourUnits = segBus[3];
  assign segMinTens   = segBus[4];
  assign segMinUnits  = segBus[5];

endmodule

// File: rtl/sixdigit_blink_disp_chk.sv
module sixdigit_blink_disp_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] slotBcd,
  input logic [7:0] hourBcd,
  input logic [7:0] minuteBcd,
  input logic [2:0] blinkMode,
  input logic [6:0] segSlotTens,
  input logic [6:0] segSlotUnits,
  input logic [6:0] segHourTens,
  input logic [6:0] segHourUnits,
  input logic [6:0] segMinTens,
  input logic [6:0] segMinUnits,
  input logic       phaseOn,
  input logic       tickPulse
);

  logic allValid;
  logic anyLit;
  assign allValid = (slotBcd[7:4] < 4'd10) && (slotBcd[3:0] < 4'd10) &&
                    (hourBcd[7:4] < 4'd10) && (hourBcd[3:0] < 4'd10) &&
                    (minuteBcd[7:4] < 4'd10) && (minuteBcd[3:0] < 4'd10);
  assign anyLit = |{segSlotTens, segSlotUnits, segHourTens,
                    segHourUnits, segMinTens, segMinUnits};

  p_bad_nibble_dark_r2: assert property (@(posedge clk) disable iff (!rstN)
    (slotBcd[7:4] > 4'd9) |-> (segSlotTens == 7'd0));

  p_idle_all_lit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (blinkMode == 3'd0 && allValid) |->
      ($countones(segSlotTens) > 0 && $countones(segSlotUnits) > 0 &&
       $countones(segHourTens) > 0 && $countones(segHourUnits) > 0 &&
       $countones(segMinTens) > 0 && $countones(segMinUnits) > 0));

  p_min_only_dark_r4: assert property (@(posedge clk) disable iff (!rstN)
    (blinkMode == 3'd1 && !phaseOn && allValid) |->
      (segMinTens == 7'd0 && segMinUnits == 7'd0 &&
       segHourTens != 7'd0 && segSlotUnits != 7'd0));

  p_all_dark_r7: assert property (@(posedge clk) disable iff (!rstN)
    (blinkMode == 3'd4 && !phaseOn) |-> !anyLit);

  p_phase_flip_on_tick_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2) && !$stable(phaseOn) &&
     $past(blinkMode) == $past(blinkMode, 2)) |-> $past(tickPulse));

  p_mode_change_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$stable(blinkMode)) |=> phaseOn);

endmodule

bind sixdigit_blink_disp sixdigit_blink_disp_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .slotBcd      (slotBcd),
  .hourBcd      (hourBcd),
  .minuteBcd    (minuteBcd),
  .blinkMode    (blinkMode),
  .segSlotTens  (segSlotTens),
  .segSlotUnits (segSlotUnits),
  .segHourTens  (segHourTens),
  .segHourUnits (segHourUnits),
  .segMinTens   (segMinTens),
  .segMinUnits  (segMinUnits),
  .phaseOn      (phaseOn),
  .tickPulse    (tickPulse)
);

// File: tb/test_sixdigit_blink_disp.sv
`timescale 1ns/1ps
module test_sixdigit_blink_disp;

  localparam int PER = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] slotBcd = 8'h12;
  logic [7:0] hourBcd = 8'h07;
  logic [7:0] minuteBcd = 8'h45;
  logic [2:0] blinkMode = 3'd0;
  logic [6:0] sST, sSU, sHT, sHU, sMT, sMU;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sixdigit_blink_disp #(.BLINK_PERIOD(PER)) i_sixdigit_blink_disp (
    .clk(clk), .rstN(rstN), .slotBcd(slotBcd), .hourBcd(hourBcd),
    .minuteBcd(minuteBcd), .blinkMode(blinkMode),
    .segSlotTens(sST), .segSlotUnits(sSU), .segHourTens(sHT),
    .segHourUnits(sHU), .segMinTens(sMT), .segMinUnits(sMU)
  );

  function automatic logic [6:0] refSeg(input logic [3:0] n);
    case (n)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
      4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
      4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
      4'd9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  // darkMask bit i = digit i from the left
  task automatic checkDigits(input logic [5:0] darkMask, input string tag);
    logic [3:0] nib [6];
    logic [6:0] act [6];
    nib[0] = slotBcd[7:4];   nib[1] = slotBcd[3:0];
    nib[2] = hourBcd[7:4];   nib[3] = hourBcd[3:0];
    nib[4] = minuteBcd[7:4]; nib[5] = minuteBcd[3:0];
    act[0] = sST; act[1] = sSU; act[2] = sHT;
    act[3] = sHU; act[4] = sMT; act[5] = sMU;
    for (int i = 0; i < 6; i++) begin
      logic [6:0] exp;
      exp = darkMask[i] ? 7'h00 : refSeg(nib[i]);
      checks++;
      if (act[i] !== exp) begin
        errors++;
        $display("FAIL %s digit %0d actual %h expected %h", tag, i, act[i], exp);
      end
    end
  endtask

  task automatic stepEdges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    stepEdges(1);
    checkDigits(6'b000000, "R11 in reset");
    @(negedge clk) rstN = 1'b1;
    stepEdges(1);
    checkDigits(6'b000000, "R11 after reset");
  endtask

  task automatic t_decode;
    for (int v = 0; v < 10; v++) begin
      @(negedge clk);
      slotBcd = {v[3:0], v[3:0]}; hourBcd = slotBcd; minuteBcd = slotBcd;
      #1 checkDigits(6'b000000, "R1 value sweep");
    end
    @(negedge clk);
    slotBcd = 8'h12; hourBcd = 8'h34; minuteBcd = 8'h56;
    #1 checkDigits(6'b000000, "R1 digit order");
    checks++;
    if (sST !== 7'h06 || sMU !== 7'h7D) begin
      errors++;
      $display("FAIL R1 ends actual %h/%h expected 06/7d", sST, sMU);
    end
  endtask

  task automatic t_invalid;
    @(negedge clk);
    slotBcd = 8'hA3; hourBcd = 8'h9F; minuteBcd = 8'hC0;
    #1 checkDigits(6'b000000, "R2 non-BCD");
    checks++;
    if (sST !== 7'h00 || sHU !== 7'h00 || sMT !== 7'h00) begin
      errors++;
      $display("FAIL R2 actual %h %h %h expected 00 00 00", sST, sHU, sMT);
    end
    @(negedge clk);
    slotBcd = 8'h12; hourBcd = 8'h34; minuteBcd = 8'h56;
  endtask

  task automatic t_mode(input logic [2:0] m, input logic [5:0] mask, input string tag);
    @(negedge clk) blinkMode = m;
    stepEdges(1);
    checkDigits(6'b000000, {tag, " R9 restart on"});
    stepEdges(PER - 1);
    checkDigits(6'b000000, {tag, " R8 last on cycle"});
    stepEdges(1);
    checkDigits(mask, {tag, " first off cycle"});
    stepEdges(PER - 1);
    checkDigits(mask, {tag, " R8 last off cycle"});
    stepEdges(1);
    checkDigits(6'b000000, {tag, " R8 back on"});
  endtask

  task automatic t_restart;
    @(negedge clk) blinkMode = 3'd1;
    stepEdges(PER + 2);
    checkDigits(6'b110000, "R9 off before change");
    @(negedge clk) blinkMode = 3'd4;
    stepEdges(1);
    checkDigits(6'b000000, "R9 change lights at once");
    stepEdges(PER - 1);
    checkDigits(6'b000000, "R9 full on phase");
    stepEdges(1);
    checkDigits(6'b111111, "R9 R7 off after restart");
  endtask

  initial begin
    t_reset();
    t_decode();
    t_invalid();
    t_mode(3'd1, 6'b110000, "R4 minute");
    t_mode(3'd2, 6'b001100, "R5 hour");
    t_mode(3'd3, 6'b000011, "R6 slot");
    t_mode(3'd4, 6'b111111, "R7 all");
    t_mode(3'd0, 6'b000000, "R3 none");
    t_mode(3'd5, 6'b000000, "R10 mode5");
    t_mode(3'd7, 6'b000000, "R10 mode7");
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule